// File: doc/BRIEF.md
# PHY Configuration Access Bridge

This block lets a host processor reach the byte-wide configuration space of a PHY through three word-wide registers. The host packs an operation, a 12-bit configuration address and a write byte into a single request word. The bridge carries the request out over a fixed number of cycles while it shows a busy flag. The host polls the completion register until busy drops, and after a read it takes the fetched byte from the same register.

Ownership of the configuration space is switchable. In internal mode a local sequencer port reaches the array directly. In host mode only packed requests reach it. A dedicated clear operation aborts any access that is still in flight and returns the bridge to its idle, internally owned state. The configuration space is modelled as a 4096-entry byte array.

Top module: `phy_cfg_bridge`

## Requirements
- R1: After reset the completion word (offset 0x18), the mode register (offset 0x10) and the request readback (offset 0x14) all read 0.
- R2: A request word written to offset 0x14 holds the opcode in bits [1:0] (0 = read, 1 = write), the configuration address in bits [15:4] and the write byte in bits [23:16]. An accepted write stores the byte in the array. An accepted read places the addressed byte in completion bits [15:8]. Offset 0x14 reads back the last accepted request word.
- R3: Completion bit 0 (busy) rises in the cycle after a request is accepted, stays set for exactly LATENCY cycles and then clears.
- R4: A read operation ignores its data field and leaves the array unchanged.
- R5: A request other than opcode 2 that arrives while busy is set is dropped and sets completion bit 1 (overrun). This bit stays set until an opcode 2 request.
- R6: Opcode 2 is accepted at any time, including while busy. In the next cycle it clears busy, overrun, the read byte and the request readback, and it sets the mode to 0. It also abandons the pending access, so the array is left unwritten.
- R7: Opcode 0 or 1 while the mode is 0, and opcode 3 in either mode, completes at once. Busy never sets, and the array, the read byte and the request readback are unchanged.
- R8: The mode register is bit 0 of offset 0x10: 1 gives the array to host requests, 0 gives it to the internal port. Writes to it while busy is set are ignored.
- R9: With mode 0, an internal-port strobe with fsm_we high writes the array. A strobe with fsm_we low loads the addressed byte onto fsm_rdata one cycle later. With mode 1 the internal port changes neither the array nor fsm_rdata.
- R10: Offsets other than 0x10, 0x14 and 0x18 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | HOST_AW | Host register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| fsm_en | input | 1 | Internal port access strobe |
| fsm_we | input | 1 | Internal port write select |
| fsm_addr | input | CFG_AW | Internal port configuration address |
| fsm_wdata | input | CFG_DW | Internal port write byte |
| fsm_rdata | output | CFG_DW | Internal port read byte, registered |

## Verification
The bench counts busy cycle by cycle after an accepted request. A design with an off-by-one latency counter would show one busy sample too few or too many. It sends a request back to back with a busy one and later reads the target address. A design that queued or executed the second request would show a changed byte or no overrun bit. It sends a clear in the middle of a write, then reads the target through the internal port. A design that let the aborted access finish would return the new byte. It also issues requests in internal mode, writes the mode register while busy, and drives the internal port in host mode. In each of these cases a leaky ownership check would show a busy flag, a changed mode or a modified array byte.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

    // Host-visible register offsets
    localparam int OFF_MODE = 'h10;
    localparam int OFF_REQ  = 'h14;
    localparam int OFF_COMP = 'h18;

    // Request word field positions
    localparam int REQ_OP_LSB   = 0;
    localparam int REQ_ADDR_LSB = 4;
    localparam int REQ_DATA_LSB = 16;

    // Completion word field positions
    localparam int COMP_BUSY_BIT = 0;
    localparam int COMP_OVR_BIT  = 1;
    localparam int COMP_BYTE_LSB = 8;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_CLEAR = 2'd2,
        OP_SPARE = 2'd3
    } op_e;

endpackage

// File: rtl/phy_cfg_array.sv
module phy_cfg_array #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/phy_cfg_arbiter.sv
module phy_cfg_arbiter #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          host_own,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic          fsm_en,
    input  logic          fsm_we,
    input  logic [AW-1:0] fsm_addr,
    input  logic [DW-1:0] fsm_wdata,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata
);
    always_comb begin
        if (host_own) begin
            arr_we    = host_we;
            arr_addr  = host_addr;
            arr_wdata = host_wdata;
        end else begin
            arr_we    = fsm_en && fsm_we;
            arr_addr  = fsm_addr;
            arr_wdata = fsm_wdata;
        end
    end

endmodule

// File: rtl/phy_cfg_bridge.sv
module phy_cfg_bridge
    import phy_cfg_pkg::*;
#(
    parameter int HOST_AW = 8,
    parameter int CFG_AW  = 12,
    parameter int CFG_DW  = 8,
    parameter int LATENCY = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    input  logic               fsm_en,
    input  logic               fsm_we,
    input  logic [CFG_AW-1:0]  fsm_addr,
    input  logic [CFG_DW-1:0]  fsm_wdata,
    output logic [CFG_DW-1:0]  fsm_rdata
);
    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);
    localparam logic [HOST_AW-1:0] A_MODE = HOST_AW'(OFF_MODE);
    localparam logic [HOST_AW-1:0] A_REQ  = HOST_AW'(OFF_REQ);
    localparam logic [HOST_AW-1:0] A_COMP = HOST_AW'(OFF_COMP);

    typedef struct packed {
        logic              busy;
        logic              ovr;
        logic              mode;
        logic [CNT_W-1:0]  cnt;
        logic [CFG_DW-1:0] rbyte;
        logic [CFG_DW-1:0] fsm_rd;
        logic [31:0]       req;
    } state_t;

    state_t s_d, s_q;

    logic              req_hit_d;
    logic              mode_hit_d;
    op_e               op_d;
    logic              done_d;
    logic              pend_wr_d;
    logic [CFG_AW-1:0] pend_addr_d;
    logic [CFG_DW-1:0] pend_data_d;
    logic              arr_we;
    logic [CFG_AW-1:0] arr_addr;
    logic [CFG_DW-1:0] arr_wdata;
    logic [CFG_DW-1:0] arr_rdata;

    // Fields of the pending request
    assign pend_addr_d = s_q.req[REQ_ADDR_LSB +: CFG_AW];
    assign pend_data_d = s_q.req[REQ_DATA_LSB +: CFG_DW];
    assign pend_wr_d   = (op_e'(s_q.req[REQ_OP_LSB +: 2]) == OP_WRITE);

    phy_cfg_arbiter #(.AW(CFG_AW), .DW(CFG_DW)) u_arb (
        .host_own   (s_q.mode),
        .host_we    (done_d && pend_wr_d),
        .host_addr  (pend_addr_d),
        .host_wdata (pend_data_d),
        .fsm_en     (fsm_en),
        .fsm_we     (fsm_we),
        .fsm_addr   (fsm_addr),
        .fsm_wdata  (fsm_wdata),
        .arr_we     (arr_we),
        .arr_addr   (arr_addr),
        .arr_wdata  (arr_wdata)
    );

    phy_cfg_array #(.AW(CFG_AW), .DW(CFG_DW)) u_arr (
        .clk   (clk),
        .we    (arr_we),
        .addr  (arr_addr),
        .wdata (arr_wdata),
        .rdata (arr_rdata)
    );

    // Next-state logic
    always_comb begin
        s_d        = s_q;
        req_hit_d  = host_we && (host_addr == A_REQ);
        mode_hit_d = host_we && (host_addr == A_MODE);
        op_d       = op_e'(host_wdata[REQ_OP_LSB +: 2]);
        done_d     = s_q.busy && (s_q.cnt == '0)
                     && !(req_hit_d && op_d == OP_CLEAR);

        // Access in flight: count down, finish on zero
        if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                s_d.busy = 1'b0;
                if (!pend_wr_d) begin
                    s_d.rbyte = arr_rdata;
                end
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end

        // New request word
        if (req_hit_d) begin
            if (op_d == OP_CLEAR) begin
                s_d.busy  = 1'b0;
                s_d.ovr   = 1'b0;
                s_d.mode  = 1'b0;
                s_d.cnt   = '0;
                s_d.rbyte = '0;
                s_d.req   = '0;
            end else if (s_q.busy) begin
                s_d.ovr = 1'b1;
            end else if (s_q.mode && (op_d == OP_READ || op_d == OP_WRITE)) begin
                s_d.busy = 1'b1;
                s_d.cnt  = CNT_LOAD;
                s_d.req  = host_wdata;
            end
        end

        // Ownership change only while idle
        if (mode_hit_d && !s_q.busy) begin
            s_d.mode = host_wdata[0];
        end

        // Internal port read capture
        if (!s_q.mode && fsm_en && !fsm_we) begin
            s_d.fsm_rd = arr_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Host register read view
    always_comb begin
        host_rdata = '0;
        if (host_addr == A_MODE) begin
            host_rdata = {31'd0, s_q.mode};
        end else if (host_addr == A_REQ) begin
            host_rdata = s_q.req;
        end else if (host_addr == A_COMP) begin
            host_rdata = (32'(s_q.rbyte) << COMP_BYTE_LSB)
                       | (32'(s_q.ovr)   << COMP_OVR_BIT)
                       | (32'(s_q.busy)  << COMP_BUSY_BIT);
        end
    end

    assign fsm_rdata = s_q.fsm_rd;

endmodule

// File: rtl/phy_cfg_bridge_checker.sv
module phy_cfg_bridge_checker
    import phy_cfg_pkg::*;
#(
    parameter int HOST_AW = 8,
    parameter int CFG_DW  = 8,
    parameter int LATENCY = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_we,
    input logic [HOST_AW-1:0] host_addr,
    input logic [31:0]        host_wdata,
    input logic               busy,
    input logic               ovr,
    input logic               mode,
    input logic [CFG_DW-1:0]  rbyte
);
    logic req_w;
    logic clr_w;
    logic go_w;
    int   run_q;

    assign req_w = host_we && (host_addr == HOST_AW'(OFF_REQ));
    assign clr_w = req_w && (host_wdata[1:0] == OP_CLEAR);
    assign go_w  = req_w && mode
                   && (host_wdata[1:0] == OP_READ || host_wdata[1:0] == OP_WRITE);

    // Consecutive busy cycles seen before the current one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 0;
        end else if (busy) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    p_busy_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go_w));

    p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q < LATENCY);

    p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && !$past(clr_w) |-> $past(run_q) == LATENCY - 1);

    p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_w && busy && !clr_w |=> ovr);

    p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovr && !clr_w |=> ovr);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> !busy && !ovr && !mode && rbyte == '0);

    p_idle_mode0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode && !busy |=> !busy);

    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !clr_w |=> $stable(mode));

endmodule

bind phy_cfg_bridge phy_cfg_bridge_checker #(
    .HOST_AW (HOST_AW),
    .CFG_DW  (CFG_DW),
    .LATENCY (LATENCY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .busy       (s_q.busy),
    .ovr        (s_q.ovr),
    .mode       (s_q.mode),
    .rbyte      (s_q.rbyte)
);

// File: tb/phy_cfg_bridge_bench.sv
`timescale 1ns/1ps
module phy_cfg_bridge_bench;
    localparam int TB_LAT = 4;
    localparam logic [7:0] O_MODE = 8'h10;
    localparam logic [7:0] O_REQ  = 8'h14;
    localparam logic [7:0] O_COMP = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        fsm_en = 1'b0;
    logic        fsm_we = 1'b0;
    logic [11:0] fsm_addr = '0;
    logic [7:0]  fsm_wdata = '0;
    logic [7:0]  fsm_rdata;

    always #4 clk = ~clk;

    phy_cfg_bridge #(.LATENCY(TB_LAT)) u_phy_cfg_bridge (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .fsm_en(fsm_en),
        .fsm_we(fsm_we), .fsm_addr(fsm_addr), .fsm_wdata(fsm_wdata),
        .fsm_rdata(fsm_rdata)
    );

    typedef struct {
        bit          from_fsm;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    logic        probe = 1'b0;
    int          n_run = 0;
    int          n_fail = 0;
    bit          ended = 1'b0;
    logic [7:0]  model [int];
    logic [7:0]  exp_rb = '0;
    logic        exp_ovr = 1'b0;
    logic [31:0] last_req = '0;

    // Monitor: compare the next expected item against the outputs
    always @(negedge clk) begin
        if (probe && sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.from_fsm ? 32'(fsm_rdata) : host_rdata;
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    function automatic logic [31:0] mkreq(logic [1:0] op, logic [11:0] a, logic [7:0] d);
        return {8'h00, d, a, 2'b00, op};
    endfunction

    function automatic logic [31:0] comp(logic b);
        return {16'h0, exp_rb, 6'b0, exp_ovr, b};
    endfunction

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(logic [7:0] off, logic [31:0] e, string tag);
        item_t it;
        it.from_fsm = 1'b0; it.exp = e; it.tag = tag;
        host_addr = off;
        sb_q.push_back(it);
        probe = 1'b1;
        @(negedge clk);
        #1 probe = 1'b0;
    endtask

    task automatic chk_fsm(logic [7:0] e, string tag);
        item_t it;
        it.from_fsm = 1'b1; it.exp = 32'(e); it.tag = tag;
        sb_q.push_back(it);
        probe = 1'b1;
        @(negedge clk);
        #1 probe = 1'b0;
    endtask

    task automatic hwrite(logic [7:0] off, logic [31:0] d);
        @(posedge clk);
        #1;
        host_we = 1'b1; host_addr = off; host_wdata = d;
        @(posedge clk);
        #1;
        host_we = 1'b0;
    endtask

    task automatic fsm_acc(logic we, logic [11:0] a, logic [7:0] d);
        @(posedge clk);
        #1;
        fsm_en = 1'b1; fsm_we = we; fsm_addr = a; fsm_wdata = d;
        @(posedge clk);
        #1;
        fsm_en = 1'b0; fsm_we = 1'b0;
    endtask

    task automatic do_wr(logic [11:0] a, logic [7:0] d);
        hwrite(O_REQ, mkreq(2'd1, a, d));
        last_req = mkreq(2'd1, a, d);
        step(TB_LAT + 1);
        model[int'(a)] = d;
        chk(O_COMP, comp(1'b0), "R2 write done");
    endtask

    task automatic do_rd(logic [11:0] a, logic [7:0] junk, string tag);
        hwrite(O_REQ, mkreq(2'd0, a, junk));
        last_req = mkreq(2'd0, a, junk);
        step(TB_LAT + 1);
        exp_rb = model[int'(a)];
        chk(O_COMP, comp(1'b0), tag);
    endtask

    initial begin
        step(5);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk(O_COMP, 32'h0, "R1 completion");
        chk(O_MODE, 32'h0, "R1 mode");
        chk(O_REQ,  32'h0, "R1 request");

        hwrite(O_MODE, 32'h1);
        chk(O_MODE, 32'h1, "R8 mode set");

        // R3 busy window, cycle by cycle
        hwrite(O_REQ, mkreq(2'd1, 12'h123, 8'hA5));
        last_req = mkreq(2'd1, 12'h123, 8'hA5);
        for (int k = 0; k < TB_LAT; k++) begin
            chk(O_COMP, comp(1'b1), "R3 busy held");
            step(1);
        end
        chk(O_COMP, comp(1'b0), "R3 busy cleared");
        model[12'h123] = 8'hA5;
        chk(O_REQ, last_req, "R2 readback");

        do_wr(12'h030, 8'h44);
        do_wr(12'h040, 8'h55);
        do_wr(12'h010, 8'h11);
        do_wr(12'hFFF, 8'h3C);
        do_wr(12'h000, 8'hC3);

        // R4 read ignores data field
        do_rd(12'h123, 8'h5A, "R4 read with junk data");
        do_rd(12'h123, 8'h00, "R4 array unchanged by read");
        do_rd(12'hFFF, 8'h77, "R2 top address");
        do_rd(12'h000, 8'h00, "R2 bottom address");

        // R5 overrun
        hwrite(O_REQ, mkreq(2'd1, 12'h020, 8'h22));
        hwrite(O_REQ, mkreq(2'd1, 12'h010, 8'h77));
        exp_ovr = 1'b1;
        chk(O_COMP, comp(1'b1), "R5 overrun while busy");
        step(TB_LAT + 1);
        model[12'h020] = 8'h22;
        last_req = mkreq(2'd1, 12'h020, 8'h22);
        chk(O_REQ, last_req, "R5 second request dropped");
        do_rd(12'h010, 8'h00, "R5 dropped write left array");

        // R8 mode write while busy is ignored
        hwrite(O_REQ, mkreq(2'd0, 12'h020, 8'h00));
        hwrite(O_MODE, 32'h0);
        step(TB_LAT + 1);
        exp_rb = 8'h22;
        chk(O_MODE, 32'h1, "R8 mode held while busy");
        chk(O_COMP, comp(1'b0), "R8 read done");

        // R6 clear while busy
        hwrite(O_REQ, mkreq(2'd1, 12'h030, 8'h99));
        hwrite(O_REQ, mkreq(2'd2, 12'h000, 8'h00));
        exp_rb = 8'h00; exp_ovr = 1'b0;
        chk(O_COMP, 32'h0, "R6 completion cleared");
        chk(O_MODE, 32'h0, "R6 mode cleared");
        chk(O_REQ,  32'h0, "R6 request cleared");
        step(TB_LAT + 1);
        chk(O_COMP, 32'h0, "R6 no late completion");

        // R7 mode 0 host requests complete at once
        hwrite(O_REQ, mkreq(2'd1, 12'h040, 8'hEE));
        chk(O_COMP, 32'h0, "R7 no busy in mode 0");
        step(TB_LAT + 1);
        hwrite(O_REQ, mkreq(2'd0, 12'h030, 8'h00));
        chk(O_COMP, 32'h0, "R7 read byte unchanged");
        chk(O_REQ, 32'h0, "R7 readback unchanged");
        fsm_acc(1'b0, 12'h040, 8'h00);
        chk_fsm(8'h55, "R7 mode 0 host write had no effect");
        fsm_acc(1'b0, 12'h030, 8'h00);
        chk_fsm(8'h44, "R6 aborted write left array");

        // R9 internal port
        fsm_acc(1'b1, 12'h050, 8'h66);
        fsm_acc(1'b0, 12'h050, 8'h00);
        chk_fsm(8'h66, "R9 internal write then read");
        model[12'h050] = 8'h66;
        hwrite(O_MODE, 32'h1);
        do_rd(12'h050, 8'h00, "R9 host sees internal write");
        fsm_acc(1'b1, 12'h050, 8'h01);
        fsm_acc(1'b0, 12'h040, 8'h00);
        chk_fsm(8'h66, "R9 internal read ignored in mode 1");
        do_rd(12'h050, 8'h00, "R9 internal write ignored in mode 1");

        // R7 spare opcode
        hwrite(O_REQ, mkreq(2'd3, 12'h050, 8'hAB));
        chk(O_COMP, comp(1'b0), "R7 spare opcode no busy");
        chk(O_REQ, last_req, "R7 spare opcode not stored");

        // R10 unused offsets
        hwrite(8'h1C, 32'hFFFF_FFFF);
        chk(8'h1C, 32'h0, "R10 unused offset reads 0");
        chk(8'h00, 32'h0, "R10 offset 0 reads 0");
        chk(O_MODE, 32'h1, "R10 mode untouched");
        chk(O_COMP, comp(1'b0), "R10 completion untouched");

        step(2);
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule